// File: doc/BRIEF.md
# Dual-Mode Serial Frame Receiver

This block turns a one-bit serial line, qualified by a bit strobe, into bytes in a small receive FIFO. It has two modes. In framed mode it deframes bit-oriented HDLC traffic. It finds the 0x7E delimiters, drops the zeros that the sender stuffed after five ones, and runs a CRC over each frame. It keeps a frame only when the first byte is the station's own address or the broadcast address. In raw mode it applies no framing. It packs every bit that arrives into bytes and stores each one.

In framed mode, bytes enter the FIFO on a provisional basis. The reader sees them only when the closing delimiter commits the frame. An abort or a frame that is too short rolls the write side back, and its bytes never become visible. When a frame completes, the block gives a one-cycle status pulse. The pulse carries the CRC result, abort and overrun. The consumer pairs each pulse with the bytes that the same commit made readable.

Top module: `hdlc_dual_rx`

## Requirements
- R1: After reset the FIFO is empty (`rd_empty`=1) and `stat_valid` is 0.
- R2: In framed mode (`raw_mode`=0) a frame lies between two 0x7E delimiters. Bytes are assembled with the first bit received in bit 0. The FIFO receives every frame byte except the last two, which are the CRC, and the bytes come out in arrival order.
- R3: In framed mode a 0 that follows five consecutive 1s is removed before byte assembly. A 0 that follows exactly six 1s is a delimiter.
- R4: The CRC is the reflected CRC-16 (polynomial 0x8408, preset 0xFFFF), taken over all frame bytes including the two CRC bytes. `stat_crc_ok`=1 when the result is 0xF0B8 and the frame is a whole number of bytes. A frame that fails the CRC is still stored, with `stat_crc_ok`=0.
- R5: A frame is accepted when its first byte equals `station_addr` or 0xFF. Any other frame writes nothing to the FIFO and gives no status.
- R6: An accepted frame with fewer than 4 bytes between its delimiters is dropped with no status and no FIFO bytes.
- R7: Seven or more consecutive 1s inside an accepted frame produce a status pulse with `stat_abort`=1 and `stat_crc_ok`=0. None of that frame's bytes become readable. Reception resumes at the next delimiter.
- R8: When the FIFO is full, further bytes of the frame are dropped. The bytes that fit are kept, and the frame's status has `stat_overrun`=1.
- R9: In raw mode every strobed bit is stored. Each group of 8 bits forms one byte, first bit in bit 0, and the byte is readable at once. Raw mode produces no status.
- R10: `stat_valid` is a one-cycle pulse in the cycle after the strobe that carries the final 0 of the closing delimiter. The frame's bytes are readable from that same cycle.
- R11: `rd_data` shows the oldest readable byte while `rd_empty`=0. `rd_en` advances to the next byte, and `rd_en` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_mode | input | 1 | 1 selects raw capture, 0 selects framed reception |
| station_addr | input | 8 | Address that frames must match (0xFF is always accepted) |
| bit_en | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Serial data bit |
| rd_en | input | 1 | Pops the oldest readable byte |
| rd_data | output | 8 | Oldest readable byte |
| rd_empty | output | 1 | No readable byte |
| stat_valid | output | 1 | Frame status pulse |
| stat_crc_ok | output | 1 | CRC residue correct and frame aligned |
| stat_abort | output | 1 | Frame ended by an abort |
| stat_overrun | output | 1 | Bytes of the frame were lost to a full FIFO |

## Verification
A bad run counter for consecutive ones is the most likely internal fault. It shows up at the ports on the next frame: stuffed bytes come out wrong, delimiters are missed, or a spurious abort pulse appears, all within one frame time. A commit pointer that moves wrongly makes bytes readable before their status pulse, or leaves bytes from a rejected frame readable. The scoreboard catches this as soon as the FIFO runs dry or holds an extra byte. A CRC or alignment fault shows up at the closing delimiter as the wrong `stat_crc_ok` value.

// File: rtl/hdlc_dual_rx.sv
module hdlc_dual_rx #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_mode,
  input  logic [7:0] station_addr,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_empty,
  output logic       stat_valid,
  output logic       stat_crc_ok,
  output logic       stat_abort,
  output logic       stat_overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] PONE = 1;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [15:0] RESIDUE = 16'hF0B8;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? 16'h8408 : 16'h0000);
    return r;
  endfunction

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wr_ptr, cm_ptr, rd_ptr;
  logic [2:0]  ones, bitcnt, bcnt;
  logic [7:0]  sh, h0, h1;
  logic [15:0] crc;
  logic        in_frame, addr_ok, ovr, raw_q;

  wire mode_chg  = raw_mode != raw_q;
  wire is_flag   = !raw_mode && bit_en && !bit_in && ones == 3'd6;
  wire is_abort  = !raw_mode && bit_en && bit_in && ones == 3'd6;
  wire take      = bit_en && (raw_mode || (bit_in ? ones < 3'd6 : ones < 3'd5));
  wire [7:0] nsh = {bit_in, sh[7:1]};
  wire byte_done = take && (raw_mode || in_frame) && bitcnt == 3'd7;
  wire full      = (wr_ptr - rd_ptr) == FULL_LVL;
  wire push      = byte_done && (raw_mode || (addr_ok && bcnt >= 3'd2));
  wire push_ok   = push && !full && !mode_chg;
  wire [7:0] push_data = raw_mode ? nsh : h1;

  assign rd_empty = cm_ptr == rd_ptr;
  assign rd_data  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; cm_ptr <= '0; rd_ptr <= '0;
      ones <= '0; bitcnt <= '0; bcnt <= '0;
      sh <= '0; h0 <= '0; h1 <= '0; crc <= 16'hFFFF;
      in_frame <= 1'b0; addr_ok <= 1'b0; ovr <= 1'b0; raw_q <= 1'b0;
      stat_valid <= 1'b0; stat_crc_ok <= 1'b0; stat_abort <= 1'b0; stat_overrun <= 1'b0;
    end else begin
      stat_valid <= 1'b0; stat_crc_ok <= 1'b0; stat_abort <= 1'b0; stat_overrun <= 1'b0;
      raw_q <= raw_mode;
      if (rd_en && !rd_empty) rd_ptr <= rd_ptr + PONE;
      if (mode_chg) begin
        ones <= '0; bitcnt <= '0; in_frame <= 1'b0; wr_ptr <= cm_ptr;
      end else begin
        if (bit_en) ones <= bit_in ? (ones == 3'd7 ? 3'd7 : ones + 3'd1) : 3'd0;
        if (take && (raw_mode || in_frame)) begin
          sh <= nsh;
          bitcnt <= bitcnt + 3'd1;
        end
        if (push_ok) begin
          wr_ptr <= wr_ptr + PONE;
          if (raw_mode) cm_ptr <= wr_ptr + PONE;
        end
        if (byte_done && !raw_mode) begin
          crc  <= crc_step(crc, nsh);
          h0   <= nsh;
          h1   <= h0;
          bcnt <= (bcnt == 3'd4) ? 3'd4 : bcnt + 3'd1;
          if (bcnt == 3'd0) addr_ok <= (nsh == station_addr) || (nsh == 8'hFF);
          if (push && full) ovr <= 1'b1;
        end
        if (is_flag) begin
          if (in_frame && addr_ok && bcnt == 3'd4) begin
            stat_valid   <= 1'b1;
            stat_crc_ok  <= (crc == RESIDUE) && (bitcnt == 3'd7);
            stat_overrun <= ovr;
            cm_ptr       <= wr_ptr;
          end else if (in_frame) begin
            wr_ptr <= cm_ptr;
          end
          in_frame <= 1'b1; bitcnt <= '0; bcnt <= '0;
          crc <= 16'hFFFF; ovr <= 1'b0; addr_ok <= 1'b0;
        end
        if (is_abort && in_frame) begin
          if (addr_ok) begin
            stat_valid <= 1'b1;
            stat_abort <= 1'b1;
          end
          wr_ptr   <= cm_ptr;
          in_frame <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_dual_rx_chk.sv
module hdlc_dual_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic raw_mode,
  input logic bit_en,
  input logic rd_empty,
  input logic stat_valid,
  input logic stat_crc_ok,
  input logic stat_abort,
  input logic stat_overrun
);
  p_abort_not_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_abort |-> (stat_valid && !stat_crc_ok));

  p_flags_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_crc_ok || stat_overrun) |-> stat_valid);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  p_status_after_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(bit_en));

  p_no_status_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_mode) && raw_mode) |-> !stat_valid);

  p_commit_with_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(raw_mode) && !$past(raw_mode, 2) && $fell(rd_empty)) |-> (stat_valid && !stat_abort));
endmodule

bind hdlc_dual_rx hdlc_dual_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .bit_en(bit_en),
  .rd_empty(rd_empty), .stat_valid(stat_valid), .stat_crc_ok(stat_crc_ok),
  .stat_abort(stat_abort), .stat_overrun(stat_overrun)
);

// File: tb/hdlc_dual_rx_test.sv
`timescale 1ns/1ps
module hdlc_dual_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, raw_mode = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
  logic mon_rd = 1'b0, tb_rd = 1'b0, hold_rd = 1'b0, done = 1'b0;
  logic [7:0] station_addr = 8'h3C;
  logic [7:0] rd_data;
  logic rd_empty, stat_valid, stat_crc_ok, stat_abort, stat_overrun;
  wire rd_en = mon_rd | tb_rd;

  int total = 0, bad = 0, ones_run = 0;
  logic [7:0] exp_b[$];
  string      exp_bt[$];
  logic [2:0] exp_s[$];
  string      exp_st[$];
  logic [7:0] tx[$];

  always #2.5 clk = ~clk;

  hdlc_dual_rx #(.DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .station_addr(station_addr),
    .bit_en(bit_en), .bit_in(bit_in), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .stat_valid(stat_valid), .stat_crc_ok(stat_crc_ok),
    .stat_abort(stat_abort), .stat_overrun(stat_overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mon_rd = 1'b0;
      if (rst_n) begin
        if (stat_valid) begin
          if (exp_s.size() == 0) chk(0, "R5 unexpected status", {stat_crc_ok, stat_abort, stat_overrun}, 0);
          else begin
            logic [2:0] e;
            string t;
            e = exp_s.pop_front();
            t = exp_st.pop_front();
            chk({stat_crc_ok, stat_abort, stat_overrun} == e, t, {stat_crc_ok, stat_abort, stat_overrun}, e);
          end
        end
        if (!rd_empty && !hold_rd) begin
          if (exp_b.size() == 0) chk(0, "R5 unexpected byte", rd_data, 0);
          else begin
            logic [7:0] e;
            string t;
            e = exp_b.pop_front();
            t = exp_bt.pop_front();
            chk(rd_data == e, t, rd_data, e);
          end
          mon_rd = 1'b1;
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_flag();
    send_bit(0);
    repeat (6) send_bit(1);
    send_bit(0);
    ones_run = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      if (b[i]) begin
        ones_run++;
        if (ones_run == 5) begin
          send_bit(0);
          ones_run = 0;
        end
      end else ones_run = 0;
    end
  endtask

  // frame in tx; n_store leading bytes expected in the FIFO; st = {crc_ok, abort, overrun}
  task automatic send_frame(input bit bad_fcs, input bit abort_it, input int n_store,
                            input bit has_st, input logic [2:0] st, input string tag);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n_store; i++) begin
      exp_b.push_back(tx[i]);
      exp_bt.push_back(tag);
    end
    if (has_st) begin
      exp_s.push_back(st);
      exp_st.push_back(tag);
    end
    repeat (3) send_bit(1);
    send_flag();
    foreach (tx[i]) begin
      send_byte(tx[i]);
      for (int k = 0; k < 8; k++) c = (c >> 1) ^ ((c[0] ^ tx[i][k]) ? 16'h8408 : 16'h0000);
    end
    if (abort_it) begin
      repeat (7) send_bit(1);
      chk(stat_valid == has_st, "R7 abort pulse timing", stat_valid, has_st);
      send_bit(1);
    end else begin
      c = ~c;
      if (bad_fcs) c = c ^ 16'h0001;
      send_byte(c[7:0]);
      send_byte(c[15:8]);
      send_flag();
      chk(stat_valid == has_st, "R10 status on closing flag", stat_valid, has_st);
      @(negedge clk);
      chk(stat_valid == 1'b0, "R10 status is one cycle", stat_valid, 0);
    end
    tx.delete();
  endtask

  task automatic wait_drain();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_empty == 1'b1, "R1 empty after reset", rd_empty, 1);
    chk(stat_valid == 1'b0, "R1 no status after reset", stat_valid, 0);

    tx = '{8'h3C, 8'h7E, 8'hFF, 8'h1F, 8'h00};
    send_frame(0, 0, 5, 1, 3'b100, "R3 stuffed frame");
    wait_drain();

    tx = '{8'hFF, 8'h42, 8'h81};
    send_frame(0, 0, 3, 1, 3'b100, "R5 broadcast frame");
    wait_drain();

    tx = '{8'h55, 8'h01, 8'h02};
    send_frame(0, 0, 0, 0, 3'b000, "R5 mismatch");
    wait_drain();
    chk(rd_empty == 1'b1, "R5 mismatch stores nothing", rd_empty, 1);

    tx = '{8'h3C, 8'hA0, 8'hB1};
    send_frame(1, 0, 3, 1, 3'b000, "R4 bad crc frame");
    wait_drain();

    tx = '{8'h3C};
    send_frame(0, 0, 0, 0, 3'b000, "R6 short frame");
    wait_drain();
    chk(rd_empty == 1'b1, "R6 short frame stores nothing", rd_empty, 1);

    tx = '{8'h3C, 8'h10, 8'h20};
    send_frame(0, 1, 0, 1, 3'b010, "R7 aborted frame");
    wait_drain();
    chk(rd_empty == 1'b1, "R7 aborted bytes hidden", rd_empty, 1);

    tx = '{8'h3C, 8'h99, 8'h66};
    send_frame(0, 0, 3, 1, 3'b100, "R7 recovery frame");
    wait_drain();

    station_addr = 8'h81;
    tx = '{8'h3C, 8'h01, 8'h02};
    send_frame(0, 0, 0, 0, 3'b000, "R5 old address rejected");
    tx = '{8'h81, 8'h0F, 8'hF0};
    send_frame(0, 0, 3, 1, 3'b100, "R5 new address accepted");
    wait_drain();

    hold_rd = 1'b1;
    @(negedge clk);
    tb_rd = 1'b1;
    @(negedge clk);
    tb_rd = 1'b0;
    chk(rd_empty == 1'b1, "R11 read on empty ignored", rd_empty, 1);
    tx = '{8'h81, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09};
    send_frame(0, 0, 8, 1, 3'b101, "R8 overrun frame");
    chk(rd_empty == 1'b0, "R8 kept bytes readable", rd_empty, 0);
    hold_rd = 1'b0;
    wait_drain();
    chk(rd_empty == 1'b1, "R11 FIFO drained", rd_empty, 1);

    raw_mode = 1'b1;
    repeat (2) @(negedge clk);
    begin
      logic [7:0] rb [3];
      rb = '{8'hA5, 8'h7E, 8'hFF};
      foreach (rb[i]) begin
        exp_b.push_back(rb[i]);
        exp_bt.push_back("R9 raw byte");
      end
      foreach (rb[i]) for (int k = 0; k < 8; k++) send_bit(rb[i][k]);
    end
    wait_drain();
    chk(exp_b.size() == 0, "R9 raw bytes all stored", exp_b.size(), 0);
    raw_mode = 1'b0;
    repeat (2) @(negedge clk);

    station_addr = 8'h3C;
    tx = '{8'hFF, 8'h5A};
    send_frame(0, 0, 2, 1, 3'b100, "R2 framed after raw");
    wait_drain();

    chk(exp_b.size() == 0, "R2 all expected bytes seen", exp_b.size(), 0);
    chk(exp_s.size() == 0, "R10 all expected status seen", exp_s.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule